// File: doc/BRIEF.md
# Synchronous Loadable Up/Down Counter

A small synchronous binary counter that moves one step up or down on every rising clock edge when both of its active-low count enables are asserted. A synchronous active-low load copies a parallel data word into the register and wins over counting. The counter has no reset of its own. Its owner brings it to a known value with a load.

An active-low terminal-count flag marks the last state in the current direction: all ones when counting up, zero when counting down. Only the trickle enable gates this flag. Several counters can therefore be chained into a wider one. Each stage's flag drives the next stage's trickle enable, and all stages share the parallel enable and the direction. The flag is a combinational decode. It may glitch and must never be used as a clock.

Top module: `updown_cnt`

## Requirements
- R1: While `load_n` is 0 at a rising edge, `q` takes the value of `din` after that edge.
- R2: A load happens whatever the levels of `cen_par_n`, `cen_trk_n` and `up`.
- R3: When `load_n` is 1, `cen_par_n` is 0, `cen_trk_n` is 0 and `up` is 1, `q` increments by one at the rising edge.
- R4: Under the same enable conditions with `up` at 0, `q` decrements by one at the rising edge.
- R5: Counting up from all ones gives 0, and counting down from 0 gives all ones.
- R6: When `load_n` is 1 and either `cen_par_n` or `cen_trk_n` is 1, `q` keeps its value.
- R7: `tc_n` is 0 when `cen_trk_n` is 0, `up` is 1 and `q` is all ones.
- R8: `tc_n` is 0 when `cen_trk_n` is 0, `up` is 0 and `q` is 0. In every other case, `tc_n` is 1.
- R9: The level of `cen_par_n` has no effect on `tc_n`.
- R10: Two counters with the low stage's `tc_n` driving the high stage's `cen_trk_n` count as one 8-bit counter, both up and down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| load_n | input | 1 | Synchronous parallel load, active low |
| cen_par_n | input | 1 | Parallel count enable, active low |
| cen_trk_n | input | 1 | Trickle count enable, active low; also gates `tc_n` |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Counter value |
| tc_n | output | 1 | Terminal-count flag, active low, combinational |

## Verification
Two situations are hard to reach at random: a carry that crosses a stage boundary in a chained pair, and the terminal state being held while the parallel enable is high. A carry into the high stage happens only once in sixteen steps, and only when the trickle chain is fully enabled. The bench therefore runs a cascaded pair through long uninterrupted sweeps, both up and down, across the full 8-bit range. Directed loads place the counter at all ones and at zero, and the parallel enable is then toggled there to show that the flag stays put while the count holds.

// File: rtl/updn_pkg.sv
package updn_pkg;
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } dir_e;

   localparam int STEP_ADDER  = 0;
   localparam int STEP_TOGGLE = 1;
endpackage

// File: rtl/updn_step.sv
module updn_step #(
   parameter int WIDTH     = 4,
   parameter int STEP_IMPL = updn_pkg::STEP_TOGGLE
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             up,
   output logic [WIDTH-1:0] nxt
);
   import updn_pkg::*;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("updn_step: WIDTH must be at least 1");
      end
      if (STEP_IMPL != STEP_ADDER && STEP_IMPL != STEP_TOGGLE) begin : g_bad_impl
         $error("updn_step: unknown STEP_IMPL");
      end

      if (STEP_IMPL == STEP_ADDER) begin : g_adder
         localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
         assign nxt = (dir_e'(up) == DIR_UP) ? cur + ONE : cur - ONE;
      end else begin : g_toggle
         logic [WIDTH-1:0] tog;
         assign tog[0] = 1'b1;
         for (genvar i = 1; i < WIDTH; i++) begin : g_bit
            assign tog[i] = tog[i-1] & (up ? cur[i-1] : ~cur[i-1]);
         end
         assign nxt = cur ^ tog;
      end
   endgenerate
endmodule

// File: rtl/updn_term.sv
module updn_term #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             up,
   input  logic             cen_trk_n,
   output logic             tc_n
);
   logic at_end;

   assign at_end = up ? (&cur) : ~(|cur);
   assign tc_n   = ~(at_end & ~cen_trk_n);
endmodule

// File: rtl/updown_cnt.sv
module updown_cnt #(
   parameter int WIDTH     = 4,
   parameter int STEP_IMPL = updn_pkg::STEP_TOGGLE
) (
   input  logic             clk,
   input  logic             load_n,
   input  logic             cen_par_n,
   input  logic             cen_trk_n,
   input  logic             up,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             tc_n
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_step;
   logic             cnt_go;

   assign cnt_go = ~cen_par_n & ~cen_trk_n;

   updn_step #(.WIDTH(WIDTH), .STEP_IMPL(STEP_IMPL)) u_step (
      .cur (cnt_q),
      .up  (up),
      .nxt (cnt_step)
   );

   updn_term #(.WIDTH(WIDTH)) u_term (
      .cur       (cnt_q),
      .up        (up),
      .cen_trk_n (cen_trk_n),
      .tc_n      (tc_n)
   );

   always_ff @(posedge clk) begin
      if (!load_n)
         cnt_q <= din;
      else if (cnt_go)
         cnt_q <= cnt_step;
   end

   assign q = cnt_q;

   // Checks become live after the first edge, once q is known.
   logic armed_q = 1'b0;
   always_ff @(posedge clk) armed_q <= 1'b1;

   assert_load_R1: assert property (@(posedge clk) disable iff (!armed_q)
      (!load_n) |=> (cnt_q == $past(din)));

   assert_count_up_R3: assert property (@(posedge clk) disable iff (!armed_q || $isunknown(cnt_q))
      (load_n && !cen_par_n && !cen_trk_n && up) |=> (cnt_q == $past(cnt_q) + 1'b1));

   assert_count_down_R4: assert property (@(posedge clk) disable iff (!armed_q || $isunknown(cnt_q))
      (load_n && !cen_par_n && !cen_trk_n && !up) |=> (cnt_q == $past(cnt_q) - 1'b1));

   assert_wrap_R5: assert property (@(posedge clk) disable iff (!armed_q || $isunknown(cnt_q))
      (load_n && !cen_par_n && !cen_trk_n && up && cnt_q == ALL_ONES) |=> (cnt_q == '0));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!armed_q || $isunknown(cnt_q))
      (load_n && (cen_par_n || cen_trk_n)) |=> $stable(cnt_q));

   assert_tc_gate_R8: assert property (@(posedge clk) disable iff (!armed_q || $isunknown(cnt_q))
      (!tc_n) |-> (!cen_trk_n && (up ? cnt_q == ALL_ONES : cnt_q == '0)));
endmodule

// File: tb/updown_cnt_bench.sv
`timescale 1ns/1ps
module updown_cnt_bench;
   localparam int W = 4;
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         load_n = 1'b1, cen_par_n = 1'b1, cen_trk_n = 1'b1, up = 1'b1;
   logic [W-1:0] din = '0;
   logic [W-1:0] q;
   logic         tc_n;

   updown_cnt #(.WIDTH(W)) u_updown_cnt (
      .clk(clk), .load_n(load_n), .cen_par_n(cen_par_n), .cen_trk_n(cen_trk_n),
      .up(up), .din(din), .q(q), .tc_n(tc_n)
   );

   // cascaded pair, adder variant
   logic         c_load_n = 1'b1, c_par_n = 1'b1, c_trk_n = 1'b1, c_up = 1'b1;
   logic [7:0]   c_din = '0;
   logic [W-1:0] lo_q, hi_q;
   logic         lo_tc_n, hi_tc_n;

   updown_cnt #(.WIDTH(W), .STEP_IMPL(0)) u_casc_lo (
      .clk(clk), .load_n(c_load_n), .cen_par_n(c_par_n), .cen_trk_n(c_trk_n),
      .up(c_up), .din(c_din[3:0]), .q(lo_q), .tc_n(lo_tc_n)
   );
   updown_cnt #(.WIDTH(W), .STEP_IMPL(0)) u_casc_hi (
      .clk(clk), .load_n(c_load_n), .cen_par_n(c_par_n), .cen_trk_n(lo_tc_n),
      .up(c_up), .din(c_din[7:4]), .q(hi_q), .tc_n(hi_tc_n)
   );

   int n_tests = 0, n_fail = 0;
   logic [W-1:0] model;

   function automatic logic [W-1:0] next_val(logic [W-1:0] cur, logic ld_n, logic p_n,
                                             logic t_n, logic u, logic [W-1:0] d);
      if (!ld_n) return d;
      if (!p_n && !t_n) return u ? cur + 1'b1 : cur - 1'b1;
      return cur;
   endfunction

   function automatic logic exp_tc_n(logic [W-1:0] cur, logic t_n, logic u);
      if (t_n) return 1'b1;
      return u ? !(cur == MAXV) : !(cur == '0);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive at negedge, check tc_n, clock, check q at next negedge.
   task automatic step(logic ld_n, logic p_n, logic t_n, logic u, logic [W-1:0] d, string req);
      load_n = ld_n; cen_par_n = p_n; cen_trk_n = t_n; up = u; din = d;
      #0.5;
      check({req, " tc_n"}, {31'd0, tc_n}, {31'd0, exp_tc_n(model, t_n, u)});
      model = next_val(model, ld_n, p_n, t_n, u, d);
      @(negedge clk);
      check({req, " q"}, {28'd0, q}, {28'd0, model});
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      @(negedge clk);
      // R1: initialise by load
      model = 'x;
      load_n = 0; din = 4'h9; cen_par_n = 1; cen_trk_n = 1;
      @(negedge clk); model = 4'h9;
      check("R1 reset-by-load", {28'd0, q}, 32'h9);
      // R2: load wins with enables active, both directions
      step(0, 0, 0, 1, 4'h3, "R2");
      step(0, 0, 0, 0, 4'hC, "R2");
      // R3 / R4
      step(1, 0, 0, 1, 4'h0, "R3");
      step(1, 0, 0, 0, 4'h0, "R4");
      // R5 + R7: up wrap
      step(0, 1, 1, 1, MAXV, "R1");
      step(1, 0, 0, 1, 4'h5, "R5 R7");
      // R5 + R8: down wrap
      step(1, 0, 0, 0, 4'h5, "R5 R8");
      // R6: hold with each enable high
      step(1, 1, 0, 1, 4'h7, "R6");
      step(1, 0, 1, 0, 4'h7, "R6");
      // R9: at all ones, parallel enable toggled; flag unchanged
      step(0, 1, 1, 1, MAXV, "R1");
      step(1, 1, 0, 1, 4'h0, "R9");
      step(1, 0, 1, 1, 4'h0, "R8 gated");
      step(0, 1, 1, 0, 4'h0, "R1");
      step(1, 1, 0, 0, 4'h0, "R9");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [7:0] r;
         r = 8'($urandom);
         step((r[2:0] != 0), r[3] & r[6], r[4] & r[7], r[5], 4'($urandom), "R3 R4 R6 R8 random");
      end
      // R10: cascade up then down
      c_din = 8'hF0; c_load_n = 0; c_par_n = 0; c_trk_n = 0; c_up = 1;
      @(negedge clk);
      c_load_n = 1;
      begin
         logic [7:0] m8;
         m8 = 8'hF0;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk); m8 = m8 + 1'b1;
            check("R10 cascade up", {24'd0, hi_q, lo_q}, {24'd0, m8});
         end
         c_up = 0;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk); m8 = m8 - 1'b1;
            check("R10 cascade down", {24'd0, hi_q, lo_q}, {24'd0, m8});
         end
         c_trk_n = 1;
         @(negedge clk);
         check("R10 cascade hold", {24'd0, hi_q, lo_q}, {24'd0, m8});
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule